// File: doc/BRIEF.md
# Receive FIFO DMA Request Controller

This block sits between the receive side of a bit-oriented serial link controller and a system DMA engine. The receiver pushes bytes into a 32-byte FIFO. After the data of each frame it pushes one status byte with an end-of-frame flag. The block turns the FIFO fill level and these frame boundaries into block-transfer requests. When the FIFO is full, it asks for a 32-byte burst. When a frame has ended, it asks for a burst that covers the bytes left over, rounded up to 4, 8, 16 or 32. Each request stays up until the DMA engine has delivered exactly that many read strobes.

When the final burst of a frame is done, the block raises a frame-done flag and exposes the number of bytes the frame put into the FIFO, status byte included. It then raises no further request until the CPU pulses an acknowledge strobe. Strobes past the remaining bytes read back 0x00 and leave the FIFO untouched. For example, a 66-byte frame takes two 32-byte bursts and then a 4-byte burst, which is 68 read strobes in total.

Top module: `rx_dma_req`

## Requirements
- R1: When no burst is active, no frame end is pending and the block is not waiting for an acknowledge, a FIFO level of 32 raises `dma_req` on the next clock edge, with `req_len` = 32.
- R2: When a frame has ended, the residual level L sets `req_len` for the final burst: L in 1..3 gives 4, 4..7 gives 8, 8..15 gives 16 and 16..32 gives 32. `req_len` holds the burst size in bytes as a plain binary number and stays constant while `dma_req` is high.
- R3: A burst of length N takes exactly N strobes of `dma_rd` while `dma_req` is high. `dma_req` falls on the clock edge that accepts the Nth strobe.
- R4: During a strobe, `rd_data` shows the oldest FIFO byte, in write order. Once the FIFO is empty, it reads 0x00 and further strobes remove nothing.
- R5: An end-of-frame byte written while a 32-byte burst is in progress is held. The final burst for it is requested once that burst completes.
- R6: When the final burst of a frame completes, `msg_end` rises and `frame_cnt` equals the number of bytes accepted for that frame. Both hold, and `dma_req` stays low, until `cmd_ack` is pulsed. The pulse clears `msg_end` and `frame_cnt`.
- R7: A write is dropped if a frame end is pending, if the final burst is active, if `msg_end` is high, or if the FIFO is full.
- R8: A `dma_rd` strobe while `dma_req` is low removes nothing.
- R9: A synchronous active-high `rst` empties the FIFO and clears `dma_req`, `msg_end`, `frame_cnt` and any pending frame end.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Receiver byte write strobe |
| wr_data | input | DW (8) | Receiver byte |
| wr_eof | input | 1 | Marks the written byte as the status byte that closes the frame |
| dma_rd | input | 1 | DMA read strobe, one byte per cycle |
| cmd_ack | input | 1 | CPU acknowledge of a completed frame |
| dma_req | output | 1 | Block transfer request |
| req_len | output | LW (6) | Size in bytes of the requested burst |
| rd_data | output | DW (8) | FIFO head byte, 0x00 when empty |
| msg_end | output | 1 | Frame fully delivered, waiting for acknowledge |
| frame_cnt | output | CW (16) | Bytes accepted for the current frame |

## Verification
A wrong fill level shows up at the ports in one of two ways. Either a 32-byte request fails to appear one cycle after the 32nd write, or the final burst has the wrong size on the cycle it is raised. A slipped read pointer corrupts `rd_data` on the very next strobe. If the read pointer runs past the stored bytes, pad reads return stale bytes instead of 0x00. A wrong strobe count leaves `dma_req` high or low one cycle off from the accepting edge. A lost pending frame end shows up as a missing final burst right after the 32-byte burst.

// File: rtl/rx_dma_req.sv
module rx_dma_req #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  parameter int CW    = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_eof,
  input  logic          dma_rd,
  input  logic          cmd_ack,
  output logic          dma_req,
  output logic [LW-1:0] req_len,
  output logic [DW-1:0] rd_data,
  output logic          msg_end,
  output logic [CW-1:0] frame_cnt
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [LW-1:0] level, beat;
  logic          pend, tail;

  wire hold       = pend | msg_end | (dma_req & tail);
  wire take       = wr_en & ~hold & (level < LW'(DEPTH));
  wire strobe     = dma_rd & dma_req;
  wire pop        = strobe & (level != '0);
  wire last       = strobe & (beat == req_len - 1'b1);
  wire idle       = ~dma_req & ~msg_end;
  wire start_tail = idle & pend;
  wire start_full = idle & ~pend & (level == LW'(DEPTH));

  function automatic logic [LW-1:0] burst_for(input logic [LW-1:0] n);
    if (n < LW'(4))       return LW'(4);
    else if (n < LW'(8))  return LW'(8);
    else if (n < LW'(16)) return LW'(16);
    else                  return LW'(DEPTH);
  endfunction

  assign rd_data = (level != '0) ? mem[rptr] : '0;

  always_ff @(posedge clk)
    if (take) mem[wptr] <= wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr      <= '0;
      rptr      <= '0;
      level     <= '0;
      beat      <= '0;
      pend      <= 1'b0;
      tail      <= 1'b0;
      dma_req   <= 1'b0;
      req_len   <= '0;
      msg_end   <= 1'b0;
      frame_cnt <= '0;
    end else begin
      if (take) begin
        wptr      <= wptr + 1'b1;
        frame_cnt <= frame_cnt + 1'b1;
        if (wr_eof) pend <= 1'b1;
      end
      if (pop) rptr <= rptr + 1'b1;
      level <= level + LW'(take) - LW'(pop);

      if (start_tail) begin
        dma_req <= 1'b1;
        req_len <= burst_for(level);
        tail    <= 1'b1;
        pend    <= 1'b0;
        beat    <= '0;
      end else if (start_full) begin
        dma_req <= 1'b1;
        req_len <= LW'(DEPTH);
        tail    <= 1'b0;
        beat    <= '0;
      end

      if (strobe) begin
        beat <= beat + 1'b1;
        if (last) begin
          dma_req <= 1'b0;
          if (tail) msg_end <= 1'b1;
        end
      end

      if (msg_end && cmd_ack) begin
        msg_end   <= 1'b0;
        frame_cnt <= '0;
      end
    end
  end

endmodule

// File: rtl/rx_dma_req_chk.sv
module rx_dma_req_chk #(
  parameter int DEPTH = 32,
  parameter int LW    = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          dma_req,
  input logic          dma_rd,
  input logic          cmd_ack,
  input logic          msg_end,
  input logic [LW-1:0] req_len,
  input logic [LW-1:0] level
);

  assert_len_legal_R2: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> (req_len == LW'(4) || req_len == LW'(8) ||
                 req_len == LW'(16) || req_len == LW'(DEPTH)));

  assert_len_stable_R2: assert property (@(posedge clk) disable iff (rst)
    dma_req && $past(dma_req) && !$past(rst) |-> $stable(req_len));

  assert_drop_on_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $fell(dma_req) |-> $past(dma_rd));

  assert_blocked_R6: assert property (@(posedge clk) disable iff (rst)
    msg_end |-> !dma_req);

  assert_no_rise_while_blocked_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $rose(dma_req) |-> !$past(msg_end));

  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (rst)
    msg_end && cmd_ack |=> !msg_end);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(DEPTH));

endmodule

bind rx_dma_req rx_dma_req_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst(rst), .dma_req(dma_req), .dma_rd(dma_rd),
  .cmd_ack(cmd_ack), .msg_end(msg_end), .req_len(req_len), .level(level)
);

// File: tb/test_rx_dma_req.sv
module test_rx_dma_req;
  logic clk = 0, rst = 1, wr_en = 0, wr_eof = 0, dma_rd = 0, cmd_ack = 0;
  logic [7:0]  wr_data = 0;
  logic        dma_req, msg_end;
  logic [5:0]  req_len;
  logic [7:0]  rd_data;
  logic [15:0] frame_cnt;
  int checks = 0, errors = 0, reads = 0;

  localparam int NV = 9;
  localparam int N_BYTES [NV] = '{1, 3, 4, 7, 8, 15, 16, 31, 32};
  localparam int EXP_LEN [NV] = '{4, 4, 8, 8, 16, 16, 32, 32, 32};

  always #4 clk = ~clk;

  rx_dma_req i_rx_dma_req (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_eof(wr_eof),
    .dma_rd(dma_rd), .cmd_ack(cmd_ack), .dma_req(dma_req), .req_len(req_len),
    .rd_data(rd_data), .msg_end(msg_end), .frame_cnt(frame_cnt)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d, input logic e);
    wr_en = 1; wr_data = d; wr_eof = e;
    @(negedge clk);
    wr_en = 0; wr_eof = 0;
  endtask

  task automatic serve(input int n, input int valid, input int base);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      dma_rd = 1;
      #1;
      if (!dma_req) bad++;
      if (rd_data != ((i < valid) ? 8'(base + i) : 8'h00)) begin
        chk("R4 rd_data", rd_data, (i < valid) ? 8'(base + i) : 0);
      end
      reads++;
      @(negedge clk);
    end
    dma_rd = 0;
    chk("R3 req held for all strobes", bad, 0);
    chk("R3 req low after last strobe", dma_req, 0);
  endtask

  task automatic ack;
    cmd_ack = 1; @(negedge clk); cmd_ack = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R9 reset req", dma_req, 0);
    chk("R9 reset msg_end", msg_end, 0);
    chk("R9 reset frame_cnt", frame_cnt, 0);
    chk("R4 empty pad", rd_data, 0);

    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < N_BYTES[v]; i++) wr(8'(8'h40 + i), i == N_BYTES[v] - 1);
      @(negedge clk);
      chk("R2 tail req", dma_req, 1);
      chk("R2 tail len", req_len, EXP_LEN[v]);
      serve(EXP_LEN[v], N_BYTES[v], 8'h40);
      chk("R6 msg_end", msg_end, 1);
      chk("R6 frame_cnt", frame_cnt, N_BYTES[v]);
      repeat (3) @(negedge clk);
      chk("R6 blocked", dma_req, 0);
      ack;
      chk("R6 ack clears", msg_end, 0);
      chk("R6 cnt cleared", frame_cnt, 0);
    end

    reads = 0;
    for (int i = 0; i < 32; i++) wr(8'(8'h40 + i), 0);
    @(negedge clk);
    chk("R1 full req", dma_req, 1);
    chk("R1 full len", req_len, 32);
    serve(32, 32, 8'h40);
    for (int i = 32; i < 64; i++) wr(8'(8'h40 + i), 0);
    @(negedge clk);
    chk("R1 second full len", req_len, 32);
    serve(32, 32, 8'h60);
    wr(8'h80, 0); wr(8'h81, 1);
    @(negedge clk);
    chk("R2 66-byte tail len", req_len, 4);
    serve(4, 2, 8'h80);
    chk("R3 68 strobes", reads, 68);
    chk("R6 66-byte cnt", frame_cnt, 66);
    ack;

    for (int i = 0; i < 32; i++) wr(8'(8'h10 + i), 0);
    @(negedge clk);
    fork
      serve(32, 32, 8'h10);
      begin
        repeat (4) @(negedge clk);
        wr(8'h30, 0); wr(8'h31, 0); wr(8'h32, 1);
      end
    join
    @(negedge clk);
    chk("R5 pending tail req", dma_req, 1);
    chk("R5 pending tail len", req_len, 4);
    serve(4, 3, 8'h30);
    chk("R5 frame_cnt", frame_cnt, 35);

    wr(8'hEE, 0); wr(8'hEF, 1);
    chk("R7 ignored while blocked", frame_cnt, 35);
    ack;
    repeat (4) @(negedge clk);
    chk("R7 no pending after ignored eof", dma_req, 0);
    chk("R7 msg_end stays low", msg_end, 0);
    wr(8'h11, 0); wr(8'h12, 1);
    @(negedge clk);
    chk("R7 clean frame len", req_len, 4);
    serve(4, 2, 8'h11);
    chk("R7 clean frame cnt", frame_cnt, 2);
    ack;

    wr(8'h50, 0); wr(8'h51, 0);
    dma_rd = 1; repeat (2) @(negedge clk); dma_rd = 0;
    chk("R8 no req from stray strobe", dma_req, 0);
    chk("R8 head kept", rd_data, 8'h50);
    wr(8'h52, 1);
    @(negedge clk);
    serve(4, 3, 8'h50);
    ack;

    wr(8'h01, 0); wr(8'h02, 0); wr(8'h03, 0);
    rst = 1; @(negedge clk); rst = 0;
    chk("R9 req after reset", dma_req, 0);
    chk("R9 cnt after reset", frame_cnt, 0);
    chk("R9 fifo emptied", rd_data, 0);
    wr(8'h77, 1);
    @(negedge clk);
    chk("R9 fresh frame len", req_len, 4);
    serve(4, 1, 8'h77);
    chk("R9 fresh frame cnt", frame_cnt, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule